// File: doc/BRIEF.md
# Two-Channel Bit-Serial Distributed-Arithmetic FIR Filter

This block computes a fixed-coefficient FIR dot product over two independent sample streams, for example the in-phase and quadrature halves of a complex signal, using a single set of serial hardware. Samples arrive one bit per clock. The least significant bit comes first. The two streams are interleaved bit by bit: the first clock of every pair carries a channel A bit and the second clock carries the matching channel B bit. A pulse on `frame_start` marks the clock that carries the least significant bit of channel A.

No multipliers are used. Taps are grouped in fours. On every clock the current bit of each tap in a group selects one entry of a 16-entry table. Each entry holds a precomputed sum of that group's coefficients. An adder tree sums the table outputs of all groups. One scaling accumulator then folds these per-bit sums into the full product. The accumulator has two registers in its loop, so the A and B sums build up on alternate clocks. The tap delay line is twice as long as one word, so each channel only sees its own history. Both channels use the same coefficients, which are fixed by a parameter.

Top module: `dsf_fir2ch`

## Requirements
- R1: Each result equals the signed sum over k = 0..TAPS-1 of coef[k] times the sample of the same channel k words earlier. Samples are DW-bit (default 13) two's complement and coefficients are CW-bit (default 12) two's complement. coef[k] occupies bits k*CW upward of the `COEFS` parameter.
- R2: Within a word, clock 2b carries bit b of channel A and clock 2b+1 carries bit b of channel B. `frame_start` is high on clock 0 only.
- R3: Bit DW-1 of each sample is the sign bit and carries weight -2^(DW-1), so the most negative input -2^(DW-1) is filtered exactly.
- R4: `y_valid` is high for exactly two consecutive clocks per word and low otherwise. The channel A result (`y_chan` = 0) appears on the clock after A's sign-bit clock, and the channel B result (`y_chan` = 1) follows on the next clock.
- R5: The two channels are independent: data on one channel never changes the other channel's results.
- R6: A clock with no word in progress and no `frame_start` is ignored. `ser_bit` has no effect then and the tap history is held.
- R7: A new `frame_start` may fall on the clock right after B's sign-bit clock. That clock starts a fresh accumulation, while the B result of the previous word is output on the same clock.
- R8: After reset `y_valid` is low and every tap holds the value zero.
- R9: Extreme coefficients (-2^(CW-1), 2^(CW-1)-1) combined with extreme inputs produce exact results without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Interleaved serial sample bit, LSB first |
| frame_start | input | 1 | High on the clock carrying channel A's LSB |
| y_valid | output | 1 | Result strobe |
| y_chan | output | 1 | Channel of the result: 0 = A, 1 = B |
| y_data | output | RW (29) | Signed filter result |

## Verification
The delicate cycle is the one right after channel B's sign bit. In that cycle the B result leaves the output register, and a fresh `frame_start` for the next word can clear channel A's accumulator input and restart the bit counter. The bench sends long runs of back-to-back words, including extreme values, so this overlap occurs on every word boundary. It compares every A and B result against its own direct-form convolution. Runs with idle gaps full of random `ser_bit` values then show that the held history lines up with the model again once words resume.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  // Sum of the coefficients of one four-tap group selected by a 4-bit address.
  function automatic int group_sum(input int c0, input int c1, input int c2,
                                   input int c3, input int addr);
    int acc;
    acc = 0;
    if (addr[0]) acc += c0;
    if (addr[1]) acc += c1;
    if (addr[2]) acc += c2;
    if (addr[3]) acc += c3;
    return acc;
  endfunction

  // Width of a signed group sum that cannot overflow.
  function automatic int lut_width(input int cw);
    return cw + 2;
  endfunction

  // Width of the tree sum across all groups.
  function automatic int tree_width(input int cw, input int groups);
    return lut_width(cw) + $clog2(groups);
  endfunction

endpackage

// File: rtl/dsf_tapline.sv
module dsf_tapline #(
  parameter int TAPS = 16,
  parameter int DW   = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            bit_in,
  output logic [TAPS-1:0] tap_bits
);
  localparam int STRIDE = 2 * DW;
  localparam int LEN    = STRIDE * (TAPS - 1);

  logic [LEN-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  line_q <= '0;
    else if (en) line_q <= {line_q[LEN-2:0], bit_in};
  end

  assign tap_bits[0] = bit_in;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tap_bits[k] = line_q[STRIDE*k-1];
  end

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(line_q));

endmodule

// File: rtl/dsf_lutbank.sv
module dsf_lutbank #(
  parameter int TAPS = 16,
  parameter int CW   = 12,
  parameter logic [TAPS*CW-1:0] COEFS = '0,
  localparam int GROUPS = TAPS / 4,
  localparam int SW = dsf_pkg::lut_width(CW),
  localparam int TW = dsf_pkg::tree_width(CW, GROUPS)
) (
  input  logic [TAPS-1:0]        tap_bits,
  output logic signed [TW-1:0]   tree_sum
);
  logic signed [SW-1:0] grp_out [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int C0 = int'($signed(COEFS[(4*g+0)*CW +: CW]));
    localparam int C1 = int'($signed(COEFS[(4*g+1)*CW +: CW]));
    localparam int C2 = int'($signed(COEFS[(4*g+2)*CW +: CW]));
    localparam int C3 = int'($signed(COEFS[(4*g+3)*CW +: CW]));
    logic signed [SW-1:0] table_q [16];
    for (genvar e = 0; e < 16; e++) begin : g_ent
      localparam int ENT = dsf_pkg::group_sum(C0, C1, C2, C3, e);
      assign table_q[e] = SW'(ENT);
    end
    assign grp_out[g] = table_q[tap_bits[4*g +: 4]];
  end

  always_comb begin
    tree_sum = '0;
    for (int g = 0; g < GROUPS; g++) tree_sum = tree_sum + TW'(grp_out[g]);
  end

endmodule

// File: rtl/dsf_accum.sv
module dsf_accum #(
  parameter int TW = 16,
  parameter int DW = 13,
  localparam int PW = TW + 1,
  localparam int RW = TW + DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first_bit,
  input  logic                 sign_bit,
  input  logic signed [TW-1:0] tsum,
  output logic signed [RW-1:0] result
);
  // Two-deep loop: each channel reads the partial written two clocks earlier.
  logic signed [PW-1:0] p1_q, p2_q;
  logic [DW-2:0]        l1_q, l2_q;
  logic signed [PW-1:0] base, addend, step;
  logic [DW-2:0]        low_in;

  always_comb begin
    base   = first_bit ? '0 : p2_q;
    low_in = first_bit ? '0 : l2_q;
    addend = PW'(tsum);
    step   = sign_bit ? (base - addend) : (base + addend);
  end

  assign result = {step, low_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q <= '0; p2_q <= '0; l1_q <= '0; l2_q <= '0;
    end else if (en) begin
      p1_q <= step >>> 1;
      l1_q <= {step[0], low_in[DW-2:1]};
      p2_q <= p1_q;
      l2_q <= l1_q;
    end
  end

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && first_bit && !sign_bit && tsum == '0) |=> (p1_q == '0));

endmodule

// File: rtl/dsf_fir2ch.sv
module dsf_fir2ch #(
  parameter int TAPS = 16,
  parameter int DW   = 13,
  parameter int CW   = 12,
  parameter logic [TAPS*CW-1:0] COEFS = '0,
  localparam int TW = dsf_pkg::tree_width(CW, TAPS / 4),
  localparam int RW = TW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_bit,
  input  logic          frame_start,
  output logic          y_valid,
  output logic          y_chan,
  output logic [RW-1:0] y_data
);
  localparam int FR = 2 * DW;
  localparam int CNW = $clog2(FR + 1);

  logic [CNW-1:0] cnt_q, idx;
  logic           run_q, active, first_bit, last_bit;
  logic [TAPS-1:0]      tap_bits;
  logic signed [TW-1:0] tree_sum;
  logic signed [RW-1:0] acc_res;

  assign active    = frame_start | run_q;
  assign idx       = frame_start ? '0 : cnt_q;
  assign first_bit = (idx < CNW'(2));
  assign last_bit  = (idx >= CNW'(FR - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (active) begin
      cnt_q <= idx + CNW'(1);
      run_q <= (idx != CNW'(FR - 1));
    end
  end

  dsf_tapline #(.TAPS(TAPS), .DW(DW)) u_line (
    .clk(clk), .rst_n(rst_n), .en(active), .bit_in(ser_bit), .tap_bits(tap_bits));

  dsf_lutbank #(.TAPS(TAPS), .CW(CW), .COEFS(COEFS)) u_luts (
    .tap_bits(tap_bits), .tree_sum(tree_sum));

  dsf_accum #(.TW(TW), .DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(active), .first_bit(first_bit),
    .sign_bit(last_bit), .tsum(tree_sum), .result(acc_res));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_valid <= 1'b0;
      y_chan  <= 1'b0;
      y_data  <= '0;
    end else begin
      y_valid <= active && last_bit;
      if (active && last_bit) begin
        y_chan <= idx[0];
        y_data <= acc_res;
      end
    end
  end

  a_r4_a_after_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (active && idx == CNW'(FR - 2)) |=> (y_valid && !y_chan));

  a_r4_valid_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> $past(active));

  a_r2_b_follows_a: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && y_chan) |-> $past(y_valid && !y_chan));

  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0 && cnt_q < CNW'(FR)));

endmodule

// File: tb/dsf_fir2ch_test.sv
module dsf_fir2ch_test;
  localparam int TAPS = 16;
  localparam int DW   = 13;
  localparam int CW   = 12;
  localparam int RW   = CW + 2 + $clog2(TAPS / 4) + DW;
  localparam int CO [TAPS] = '{2047, -2048, 100, -5, 7, 300, -1000, 1,
                               0, 55, -77, 1234, -1500, 9, 2047, -2048};

  function automatic logic [TAPS*CW-1:0] pack_coefs();
    logic [TAPS*CW-1:0] v;
    for (int k = 0; k < TAPS; k++) v[k*CW +: CW] = CW'(CO[k]);
    return v;
  endfunction
  localparam logic [TAPS*CW-1:0] PK = pack_coefs();

  logic clk = 1'b0, rst_n = 1'b0, ser_bit = 1'b0, frame_start = 1'b0;
  logic y_valid, y_chan;
  logic [RW-1:0] y_data;

  dsf_fir2ch #(.TAPS(TAPS), .DW(DW), .CW(CW), .COEFS(PK)) uut (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .frame_start(frame_start),
    .y_valid(y_valid), .y_chan(y_chan), .y_data(y_data));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int hist [2][TAPS];
  longint exp_q0 [$];
  longint exp_q1 [$];
  int got_cnt = 0;
  int expect_chan = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Output monitor: every strobe is compared with the model (R1, R4).
  always @(negedge clk) begin
    if (rst_n && y_valid) begin
      longint act, e;
      act = longint'($signed(y_data));
      got_cnt++;
      check(int'(y_chan) == expect_chan, "R4 channel order", longint'(y_chan), longint'(expect_chan));
      if (y_chan == 1'b0) begin
        if (exp_q0.size() == 0) check(0, "R4 unexpected A strobe", act, 0);
        else begin e = exp_q0.pop_front(); check(act == e, "R1 channel A result", act, e); end
      end else begin
        if (exp_q1.size() == 0) check(0, "R4 unexpected B strobe", act, 0);
        else begin e = exp_q1.pop_front(); check(act == e, "R1 channel B result", act, e); end
      end
      expect_chan = 1 - int'(y_chan);
    end
  end

  function automatic longint model(input int ch, input int s);
    longint acc = 0;
    for (int k = TAPS - 1; k > 0; k--) hist[ch][k] = hist[ch][k-1];
    hist[ch][0] = s;
    for (int k = 0; k < TAPS; k++) acc += longint'(CO[k]) * longint'(hist[ch][k]);
    return acc;
  endfunction

  task automatic send_word(input int a, input int b);
    logic [DW-1:0] wa, wb;
    wa = DW'(a); wb = DW'(b);
    exp_q0.push_back(model(0, a));
    exp_q1.push_back(model(1, b));
    for (int i = 0; i < 2 * DW; i++) begin
      @(negedge clk);
      frame_start = (i == 0);
      ser_bit = (i % 2 == 0) ? wa[i/2] : wb[i/2];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_start = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ser_bit = lfsr[0];
    end
  endtask

  task automatic drain_check(input string req, input int want);
    idle(3);
    check(exp_q0.size() == 0 && exp_q1.size() == 0, req,
          longint'(exp_q0.size() + exp_q1.size()), 0);
    check(got_cnt == want, {req, " strobe count"}, got_cnt, want);
    got_cnt = 0;
  endtask

  function automatic int rnd_sample();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[DW-1:0]));
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(y_valid == 1'b0, "R8 valid low in reset", longint'(y_valid), 0);
    rst_n = 1'b1;
    idle(4);
    check(y_valid == 1'b0, "R8 valid low after reset", longint'(y_valid), 0);
  endtask

  // R8, R5: impulse on A with zero history yields the coefficients; B stays zero.
  task automatic t_impulse();
    send_word(1, 0);
    for (int i = 1; i < TAPS; i++) send_word(0, 0);
    drain_check("R5 impulse", 2 * TAPS);
  endtask

  // R3, R9: most negative and most positive samples against extreme coefficients.
  task automatic t_extremes();
    for (int i = 0; i < TAPS + 2; i++) send_word(-4096, 4095);
    send_word(4095, -4096);
    send_word(-1, -4096);
    drain_check("R3 R9 extremes", 2 * (TAPS + 4));
  endtask

  // R7: back-to-back pseudo-random words, start coincides with B output.
  task automatic t_stream();
    for (int i = 0; i < 60; i++) send_word(rnd_sample(), rnd_sample());
    drain_check("R7 back-to-back", 120);
  endtask

  // R6: idle gaps with garbage on ser_bit leave the history untouched.
  task automatic t_gaps();
    for (int i = 0; i < 20; i++) begin
      send_word(rnd_sample(), rnd_sample());
      idle(1 + (i % 5) * 3);
    end
    drain_check("R6 idle gaps", 40);
  endtask

  // R2, R5: one channel silent while the other carries data, then swapped.
  task automatic t_isolation();
    for (int i = 0; i < TAPS; i++) send_word(rnd_sample(), 0);
    for (int i = 0; i < TAPS; i++) send_word(0, rnd_sample());
    drain_check("R2 R5 isolation", 4 * TAPS);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int k = 0; k < TAPS; k++) hist[c][k] = 0;
    t_reset();
    t_impulse();
    t_extremes();
    t_stream();
    t_gaps();
    t_isolation();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule